// File: doc/BRIEF.md
# Local Scan Port Park Controller

This block sits behind the primary test access port of a scan gateway and manages six downstream local scan ports. Each local port receives its TMS from the block. While a port is unparked, its TMS follows the primary TMS, so its TAP controller moves in step with the primary one. While a port is parked, its TMS is held at the level that keeps its TAP in one of four stable states. A park or unpark request is decoded from the instruction opcode. The request is recorded at once. It only changes the port when the primary TAP next sits in the state that the port is (or will be) parked in, so the two controllers never drift apart.

The block also builds the active scan path. The serial output of the gateway's own register feeds a first section of up to three ports, which leads to a middle node. A second section of up to three ports runs from the middle node to the chain output. A 16-bit mode word picks which ports belong to each section. Every port that is picked and not parked is inserted into the path. A one-bit pad flop follows each inserted port. A section whose ports are all unpicked or parked is passed by with a wire.

Top module: `lsp_park_ctrl`

## Requirements
- R1: After a cycle with `rst` high, all six ports are parked in Test-Logic-Reset. Every `lsp_tms` bit reads 1 whatever `tms` is, every `lsp_tdi` bit reads 1, and `chain_out` equals `reg_so`.
- R2: An unpark request (opcode 0xE7) on a parked port takes effect only in a cycle where `tap_state` equals the port's park state. In that cycle the port's TMS already follows `tms`, and from the next rising edge the port counts as unparked.
- R3: An unparked port drives `lsp_tms` equal to `tms` in the same cycle while the primary TAP is not completing a pending park.
- R4: A park-in-Run-Test-Idle request (opcode 0x84) leaves the port following `tms` until `tap_state` equals Run-Test-Idle (code 1). From that cycle on, the port's TMS is held at 0.
- R5: A park-in-pause request (opcode 0xC6) parks the port when `tap_state` first equals Pause-DR (code 6) or Pause-IR (code 13), and its TMS is held at 0. A later unpark completes only in the same pause state the port was parked in.
- R6: Mode bits [10:8] select ports 0, 1 and 2 (bit 8 is port 0). These ports are inserted, in index order, between `reg_so` and the middle node.
- R7: Mode bits [2:0] select ports 3, 4 and 5 (bit 0 is port 3). These ports are inserted, in index order, between the middle node and `chain_out`. All other mode bits are ignored.
- R8: Each inserted port drives its `lsp_tdi` from a falling-edge flop, and a rising-edge pad flop follows its `lsp_tdo`. An inserted port whose own path is L stages long therefore adds L+1 TCK cycles to the path.
- R9: Parked ports are left out of the path. When no port is inserted, `chain_out` equals `reg_so` combinationally.
- R10: A port that is not inserted has its `lsp_tdi` held at 1.
- R11: Opcodes other than 0xE7, 0xC5, 0x84 and 0xC6 leave every port unchanged. A request applies only to the ports selected by the mode word in the cycle `op_load` is high. A park request on a parked port is ignored, and so is an unpark request on an unparked port.
- R12: A park-in-Test-Logic-Reset request (opcode 0xC5) parks the port when `tap_state` equals Test-Logic-Reset (code 0), and its TMS is then held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Primary test clock |
| rst | input | 1 | Synchronous active-high reset, taken from the primary TAP reset |
| tms | input | 1 | Primary test mode select |
| tap_state | input | 4 | Primary TAP state code (0 TLR, 1 RTI, 6 Pause-DR, 13 Pause-IR; other codes are moving states) |
| op_load | input | 1 | One-cycle strobe: `op_code` holds a newly updated instruction |
| op_code | input | 8 | Current instruction opcode |
| mode | input | 16 | Port selection word |
| reg_so | input | 1 | Serial output of the gateway's own selected register |
| lsp_tdo | input | 6 | Serial data returned by each local port |
| lsp_tms | output | 6 | TMS driven to each local port |
| lsp_tdi | output | 6 | Serial data driven to each local port |
| chain_out | output | 1 | Combined path output toward the primary TDO |

## Verification
The assertions assume a `tap_state` that changes only after a rising edge and a `mode` and `op_load` that change at the same time, so both are steady at the following falling edge. They also assume that no request arrives in the cycle in which a pending request completes. The bench drives every input a quarter period after the rising edge and keeps the TAP in a moving state whenever it issues a request. It enters a stable state only on purpose, for one or two cycles. The local ports are modelled as shift paths of different lengths that launch on the falling edge, so every insertion shows up as a different path delay.

// File: rtl/lsp_park_pkg.sv
package lsp_park_pkg;

  typedef enum logic [3:0] {
    TS_TLR      = 4'd0,
    TS_RTI      = 4'd1,
    TS_SEL_DR   = 4'd2,
    TS_CAP_DR   = 4'd3,
    TS_SH_DR    = 4'd4,
    TS_EX1_DR   = 4'd5,
    TS_PAUSE_DR = 4'd6,
    TS_EX2_DR   = 4'd7,
    TS_UPD_DR   = 4'd8,
    TS_SEL_IR   = 4'd9,
    TS_CAP_IR   = 4'd10,
    TS_SH_IR    = 4'd11,
    TS_EX1_IR   = 4'd12,
    TS_PAUSE_IR = 4'd13,
    TS_EX2_IR   = 4'd14,
    TS_UPD_IR   = 4'd15
  } tap_st_t;

  // pending request held per port until the primary TAP reaches the target
  typedef enum logic [2:0] {
    PD_NONE,
    PD_TLR,
    PD_RTI,
    PD_PAUSE,
    PD_WAKE
  } pend_t;

  localparam int OP_W = 8;
  localparam logic [OP_W-1:0] OP_WAKE       = 8'hE7;
  localparam logic [OP_W-1:0] OP_HOLD_TLR   = 8'hC5;
  localparam logic [OP_W-1:0] OP_HOLD_RTI   = 8'h84;
  localparam logic [OP_W-1:0] OP_HOLD_PAUSE = 8'hC6;

  function automatic logic is_rest(input tap_st_t s);
    return (s == TS_TLR) || (s == TS_RTI) ||
           (s == TS_PAUSE_DR) || (s == TS_PAUSE_IR);
  endfunction

endpackage

// File: rtl/lsp_park_decode.sv
module lsp_park_decode
  import lsp_park_pkg::*;
#(
  parameter int NPORT = 6
) (
  input  logic             op_load,
  input  logic [OP_W-1:0]  op_code,
  input  logic [NPORT-1:0] sel,
  output logic [NPORT-1:0] req_park,
  output pend_t            req_kind,
  output logic [NPORT-1:0] req_wake
);

  logic is_park;
  logic is_wake;

  always_comb begin
    req_kind = PD_NONE;
    is_park  = 1'b0;
    is_wake  = 1'b0;
    if (op_load) begin
      case (op_code)
        OP_HOLD_TLR:   begin req_kind = PD_TLR;   is_park = 1'b1; end
        OP_HOLD_RTI:   begin req_kind = PD_RTI;   is_park = 1'b1; end
        OP_HOLD_PAUSE: begin req_kind = PD_PAUSE; is_park = 1'b1; end
        OP_WAKE:       begin is_wake = 1'b1; end
        default:       begin end
      endcase
    end
  end

  assign req_park = is_park ? sel : '0;
  assign req_wake = is_wake ? sel : '0;

endmodule

// File: rtl/lsp_port_park.sv
module lsp_port_park
  import lsp_park_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    tms,
  input  tap_st_t tap,
  input  logic    req_park,
  input  pend_t   req_kind,
  input  logic    req_wake,
  output logic    parked,
  output logic    tms_out
);

  logic    parked_q;
  tap_st_t at_q;
  pend_t   pend_q;
  logic    hit_park;
  logic    hit_wake;
  logic    hold;
  logic    hold_lvl;

  // completion happens in the cycle the primary TAP sits in the target state
  always_comb begin
    hit_park = 1'b0;
    if (!parked_q) begin
      case (pend_q)
        PD_TLR:   hit_park = (tap == TS_TLR);
        PD_RTI:   hit_park = (tap == TS_RTI);
        PD_PAUSE: hit_park = (tap == TS_PAUSE_DR) || (tap == TS_PAUSE_IR);
        default:  hit_park = 1'b0;
      endcase
    end
    hit_wake = parked_q && (pend_q == PD_WAKE) && (tap == at_q);
    hold     = parked_q ? !hit_wake : hit_park;
    hold_lvl = parked_q ? (at_q == TS_TLR) : (tap == TS_TLR);
    tms_out  = hold ? hold_lvl : tms;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      parked_q <= 1'b1;
      at_q     <= TS_TLR;
      pend_q   <= PD_NONE;
    end else begin
      if (hit_park) begin
        parked_q <= 1'b1;
        at_q     <= tap;
        pend_q   <= PD_NONE;
      end else if (hit_wake) begin
        parked_q <= 1'b0;
        pend_q   <= PD_NONE;
      end
      if (req_park && !parked_q && !hit_park) begin
        pend_q <= req_kind;
      end else if (req_wake && parked_q && !hit_wake) begin
        pend_q <= PD_WAKE;
      end
    end
  end

  assign parked = parked_q;

endmodule

// File: rtl/lsp_chain_section.sv
module lsp_chain_section #(
  parameter int PORTS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sin,
  input  logic [PORTS-1:0] ins,
  input  logic [PORTS-1:0] port_so,
  output logic [PORTS-1:0] port_si,
  output logic             sout
);

  logic [PORTS-1:0] pad_q;
  logic [PORTS-1:0] si_q;
  logic [PORTS-1:0] feed;

  // walk the section: each inserted port replaces the running node by its pad
  always_comb begin
    logic node;
    node = sin;
    for (int j = 0; j < PORTS; j++) begin
      feed[j] = node;
      if (ins[j]) node = pad_q[j];
    end
    sout = node;
  end

  always_ff @(posedge clk) begin
    if (rst) pad_q <= '0;
    else     pad_q <= port_so;
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      si_q <= '1;
    end else begin
      for (int j = 0; j < PORTS; j++) begin
        si_q[j] <= ins[j] ? feed[j] : 1'b1;
      end
    end
  end

  assign port_si = si_q;

endmodule

// File: rtl/lsp_park_ctrl.sv
module lsp_park_ctrl
  import lsp_park_pkg::*;
#(
  parameter int SECTIONS      = 2,
  parameter int PORTS_PER_SEC = 3,
  parameter int MODE_W        = 16,
  parameter int FIELD_STRIDE  = 8
) (
  input  logic                                tck,
  input  logic                                rst,
  input  logic                                tms,
  input  logic [3:0]                          tap_state,
  input  logic                                op_load,
  input  logic [OP_W-1:0]                     op_code,
  input  logic [MODE_W-1:0]                   mode,
  input  logic                                reg_so,
  input  logic [SECTIONS*PORTS_PER_SEC-1:0]   lsp_tdo,
  output logic [SECTIONS*PORTS_PER_SEC-1:0]   lsp_tms,
  output logic [SECTIONS*PORTS_PER_SEC-1:0]   lsp_tdi,
  output logic                                chain_out
);

  localparam int NPORT = SECTIONS * PORTS_PER_SEC;

  tap_st_t          tap_q;
  logic [NPORT-1:0] sel;
  logic [NPORT-1:0] req_park;
  logic [NPORT-1:0] req_wake;
  pend_t            req_kind;
  logic [NPORT-1:0] parked_mask;
  logic [NPORT-1:0] ins_mask;
  logic [SECTIONS:0] link;
  logic             unused_mode_bits;

  assign tap_q = tap_st_t'(tap_state);
  assign unused_mode_bits = ^mode;

  // first section takes the highest field, last section the lowest
  for (genvar s = 0; s < SECTIONS; s++) begin : g_sel
    for (genvar j = 0; j < PORTS_PER_SEC; j++) begin : g_bit
      assign sel[s*PORTS_PER_SEC + j] = mode[(SECTIONS-1-s)*FIELD_STRIDE + j];
    end
  end

  lsp_park_decode #(.NPORT(NPORT)) u_dec (
    .op_load  (op_load),
    .op_code  (op_code),
    .sel      (sel),
    .req_park (req_park),
    .req_kind (req_kind),
    .req_wake (req_wake)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    lsp_port_park u_port (
      .clk      (tck),
      .rst      (rst),
      .tms      (tms),
      .tap      (tap_q),
      .req_park (req_park[p]),
      .req_kind (req_kind),
      .req_wake (req_wake[p]),
      .parked   (parked_mask[p]),
      .tms_out  (lsp_tms[p])
    );
  end

  assign ins_mask = sel & ~parked_mask;
  assign link[0]  = reg_so;

  for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
    lsp_chain_section #(.PORTS(PORTS_PER_SEC)) u_sec (
      .clk     (tck),
      .rst     (rst),
      .sin     (link[s]),
      .ins     (ins_mask[s*PORTS_PER_SEC +: PORTS_PER_SEC]),
      .port_so (lsp_tdo[s*PORTS_PER_SEC +: PORTS_PER_SEC]),
      .port_si (lsp_tdi[s*PORTS_PER_SEC +: PORTS_PER_SEC]),
      .sout    (link[s+1])
    );
  end

  assign chain_out = link[SECTIONS];

endmodule

// File: rtl/lsp_park_ctrl_chk.sv
module lsp_park_ctrl_chk
  import lsp_park_pkg::*;
#(
  parameter int NPORT = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             tms,
  input logic [3:0]       tap_state,
  input logic             reg_so,
  input logic             chain_out,
  input logic [NPORT-1:0] lsp_tms,
  input logic [NPORT-1:0] lsp_tdi,
  input logic [NPORT-1:0] ins_mask,
  input logic [NPORT-1:0] parked_mask
);

  p_bypass_wire_r9: assert property (@(posedge clk) disable iff (rst)
    (ins_mask == '0) |-> (chain_out == reg_so));

  p_idle_tdi_r10: assert property (@(posedge clk) disable iff (rst)
    ((~ins_mask) & ~lsp_tdi) == '0);

  for (genvar i = 0; i < NPORT; i++) begin : g_a
    p_park_at_rest_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(parked_mask[i]) |-> is_rest(tap_st_t'($past(tap_state))));

    p_wake_at_rest_r2: assert property (@(posedge clk) disable iff (rst)
      $fell(parked_mask[i]) |-> is_rest(tap_st_t'($past(tap_state))));

    p_follow_moving_r3: assert property (@(posedge clk) disable iff (rst)
      (!parked_mask[i] && !is_rest(tap_st_t'(tap_state))) |-> (lsp_tms[i] == tms));
  end

endmodule

bind lsp_park_ctrl lsp_park_ctrl_chk #(.NPORT(NPORT)) u_chk (
  .clk         (tck),
  .rst         (rst),
  .tms         (tms),
  .tap_state   (tap_state),
  .reg_so      (reg_so),
  .chain_out   (chain_out),
  .lsp_tms     (lsp_tms),
  .lsp_tdi     (lsp_tdi),
  .ins_mask    (ins_mask),
  .parked_mask (parked_mask)
);

// File: tb/lsp_park_ctrl_test.sv
`timescale 1ns/1ps
module lsp_park_ctrl_test;

  localparam int TS_TLR = 0, TS_RTI = 1, TS_SH = 4, TS_PDR = 6, TS_PIR = 13;

  // {mode[15:0], expected path delay in cycles}; port p models a path of p+1 stages
  localparam logic [23:0] VEC [13] = '{
    24'h000001, 24'h010002, 24'h020003, 24'h040004, 24'h030005,
    24'h070009, 24'h000105, 24'h000206, 24'h000407, 24'h07071B,
    24'h050512, 24'hF8F801, 24'h02030E
  };

  logic       tck = 1'b0;
  logic       rst = 1'b1;
  logic       tms = 1'b1;
  logic [3:0] tap_state = 4'(TS_TLR);
  logic       op_load = 1'b0;
  logic [7:0] op_code = 8'h00;
  logic [15:0] mode = 16'h0000;
  logic       reg_so = 1'b0;
  logic [5:0] lsp_tdo = '0;
  logic [5:0] lsp_tms;
  logic [5:0] lsp_tdi;
  logic       chain_out;

  int nchk = 0;
  int nfail = 0;
  logic [5:0] dev [6];
  logic [7:0] lfsr = 8'hA5;

  always #10 tck = ~tck;

  lsp_park_ctrl uut (
    .tck(tck), .rst(rst), .tms(tms), .tap_state(tap_state),
    .op_load(op_load), .op_code(op_code), .mode(mode), .reg_so(reg_so),
    .lsp_tdo(lsp_tdo), .lsp_tms(lsp_tms), .lsp_tdi(lsp_tdi),
    .chain_out(chain_out)
  );

  // local port models: capture on rising edge, launch on falling edge
  initial for (int i = 0; i < 6; i++) dev[i] = '0;
  always @(posedge tck) for (int i = 0; i < 6; i++) dev[i] <= {dev[i][4:0], lsp_tdi[i]};
  always @(negedge tck) for (int i = 0; i < 6; i++) lsp_tdo[i] <= dev[i][i];

  task automatic tick();
    @(posedge tck);
    #5;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tms_chk(input string tag, input logic [5:0] exp);
    #1;
    chk(tag, 32'(lsp_tms), 32'(exp));
  endtask

  task automatic load_op(input logic [7:0] code, input logic [15:0] m);
    mode = m;
    op_code = code;
    op_load = 1'b1;
    tick();
    op_load = 1'b0;
  endtask

  task automatic run_shift(input string tag, input int dly, input logic [5:0] ins);
    logic [127:0] hist;
    int bad_dat;
    int bad_tdi;
    logic [5:0] tdi_seen;
    hist = '0;
    bad_dat = 0;
    bad_tdi = 0;
    tdi_seen = '1;
    for (int c = 0; c < dly + 40; c++) begin
      tick();
      if (c >= dly && chain_out !== hist[c-dly]) bad_dat++;
      if (c > 0 && (((~ins) & ~lsp_tdi) != 0)) begin
        bad_tdi++;
        tdi_seen = lsp_tdi;
      end
      hist[c] = lfsr[0];
      reg_so = lfsr[0];
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
    chk({tag, " path data mismatches"}, 32'(bad_dat), 32'd0);
    chk({tag, " R10 idle tdi"}, 32'(tdi_seen | ins), 32'h3F);
  endtask

  initial begin : watchdog
    #(20 * 200000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin : main
    tick(); tick(); tick();
    rst = 1'b0;
    tms = 1'b0;
    // R1 reset state
    tms_chk("R1 tms after reset", 6'h3F);
    chk("R1 tdi after reset", 32'(lsp_tdi), 32'h3F);
    reg_so = 1'b1; #1;
    chk("R1 bypass high", 32'(chain_out), 32'd1);
    reg_so = 1'b0; #1;
    chk("R1 bypass low", 32'(chain_out), 32'd0);

    // R2 unpark waits for TLR
    tap_state = 4'(TS_SH);
    load_op(8'hE7, 16'h0707);
    tap_state = 4'(TS_RTI); tms = 1'b0;
    tms_chk("R2 still parked in RTI", 6'h3F);
    tap_state = 4'(TS_TLR);
    tms_chk("R2 follows at TLR", 6'h00);
    tick();
    tap_state = 4'(TS_SH);
    tms = 1'b1; tms_chk("R3 follow high", 6'h3F);
    tms = 1'b0; tms_chk("R3 follow low", 6'h00);

    // R6 R7 R8 table of mode words, all ports unparked
    for (int v = 0; v < 13; v++) begin
      mode = VEC[v][23:8];
      run_shift($sformatf("R6 R7 R8 mode %04h", VEC[v][23:8]), int'(VEC[v][7:0]),
                {VEC[v][10:8], VEC[v][18:16]});
    end

    // R11 ignored opcode
    load_op(8'h55, 16'h0707);
    tap_state = 4'(TS_RTI); tms = 1'b1;
    tms_chk("R11 unknown opcode in RTI", 6'h3F);
    tick();
    tms_chk("R11 unknown opcode next cycle", 6'h3F);

    // R4 park in RTI for ports 0 and 5
    tap_state = 4'(TS_SH);
    load_op(8'h84, 16'h0104);
    tms_chk("R4 not yet parked", 6'h3F);
    tick();
    tap_state = 4'(TS_RTI);
    tms_chk("R4 held at RTI", 6'b011110);
    tick();
    tap_state = 4'(TS_SH);
    tms_chk("R4 stays parked", 6'b011110);
    mode = 16'h0707;
    run_shift("R9 parked ports skipped", 18, 6'b011110);

    // R5 park port 4 in pause, wake only in same pause
    load_op(8'hC6, 16'h0002);
    tap_state = 4'(TS_PDR);
    tms_chk("R5 parks at Pause-DR", 6'b001110);
    tick();
    tap_state = 4'(TS_SH);
    tms_chk("R5 stays parked", 6'b001110);
    load_op(8'hE7, 16'h0002);
    tap_state = 4'(TS_PIR);
    tms_chk("R5 no wake in Pause-IR", 6'b001110);
    tick();
    tap_state = 4'(TS_PDR);
    tms_chk("R5 wakes in Pause-DR", 6'b011110);
    tick();
    tap_state = 4'(TS_SH);
    tms_chk("R5 awake afterwards", 6'b011110);

    // R12 park the free ports in TLR
    load_op(8'hC5, 16'h0707);
    tap_state = 4'(TS_TLR); tms = 1'b0;
    tms_chk("R12 held high at TLR", 6'b011110);
    tick();
    tap_state = 4'(TS_SH);
    tms_chk("R12 stays high", 6'b011110);
    mode = 16'h0707;
    run_shift("R9 all parked bypass", 1, 6'b000000);

    // R11 only selected ports respond
    load_op(8'hE7, 16'h0100);
    tap_state = 4'(TS_RTI); tms = 1'b1;
    tms_chk("R11 only port 0 wakes", 6'b011111);
    tick();
    tap_state = 4'(TS_SH); tms = 1'b0;
    tms_chk("R11 port 0 follows", 6'b011110);

    // R1 reset again
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    tms = 1'b0;
    tms_chk("R1 tms after second reset", 6'h3F);
    chk("R1 tdi after second reset", 32'(lsp_tdi), 32'h3F);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule